// File: doc/BRIEF.md
# 32-bit Multiplicative Congruential Random Word Generator

This block returns one pseudo-random 32-bit word each time it is asked for one. It keeps a 64-bit state that is always odd. Each step multiplies the state by a fixed odd constant, modulo 2^64, and adds nothing. The word comes from the state as it was before that step. The state is first xor-folded with a copy of itself shifted right, and the result is then shifted right by an amount that the top three state bits select.

A client can reseed the generator at any time with a 64-bit value. The generator forces the seed odd and throws away the first word that the new state would give, so the first word the client sees is already one step into the sequence. Out of reset the generator starts from a fixed odd state and gives words from it straight away.

Top module: `mcg_rand32`

## Requirements
- R1: While `rst` is high at a rising edge, the state takes the value 0xcafef00dd15ea5e5 and `rnd` and `rnd_valid` clear to 0. The first word requested after reset is derived from that state.
- R2: Each accepted request replaces the state S with (S * 6364136223846793005) mod 2^64, with no increment. A cycle that has neither a request nor a seed load leaves the state unchanged.
- R3: The word for state S is found in three steps: c = S[63:61], X = S xor (S >> 22), and `rnd` = bits 31:0 of (X >> (22 + c)). The word uses the state from before the update of the same request.
- R4: A seed load with value V sets the state to ((2*V + 1) mod 2^64) * 6364136223846793005 mod 2^64. This discards the word of the seeded state, so the first word requested after the load is the permuted value of that product.
- R5: A request accepted at edge k drives `rnd_valid` high after edge k and sets `rnd` to its word. After any edge with no accepted request, `rnd_valid` is low and `rnd` keeps its previous value. Back-to-back requests give a new word every cycle.
- R6: When `seed_load` and `next` are both high at the same edge, only the seed load takes effect. No word is produced, and the next word requested follows R4.
- R7: The state is odd at all times, including after a seed whose doubled value overflows 64 bits (for example a seed with only bit 63 set, or a seed of all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed` into the state (takes priority over `next`) |
| seed | input | 64 | Seed value |
| next | input | 1 | Request one new word |
| rnd | output | 32 | Last produced random word |
| rnd_valid | output | 1 | High for one cycle after each accepted request |

## Verification
The bench builds the block with its default parameters: a 64-bit state, a 32-bit word, a 3-bit shift selector, a fold shift of 22, and the shift-operator variant of the output stage. Under these values the reference model's 64-bit unsigned arithmetic wraps exactly as the hardware does. Long runs of requests with gaps in them pass through all eight values of the shift selector. The chosen seeds (zero, all ones, only the top bit set, and ordinary values) reach the point where the doubling step drops the top bit.

// File: rtl/mcg_rand_pkg.sv
package mcg_rand_pkg;

   localparam logic [63:0] MCG_MULT_64  = 64'd6364136223846793005;
   localparam logic [63:0] MCG_RESET_64 = 64'hcafef00dd15ea5e5;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_STEP = 2'd1,
      OP_SEED = 2'd2
   } mcg_op_e;

   // seed load wins over a word request in the same cycle
   function automatic mcg_op_e mcg_decode(input logic load, input logic req);
      if (load)     return OP_SEED;
      else if (req) return OP_STEP;
      else          return OP_IDLE;
   endfunction

endpackage

// File: rtl/mcg_rand_state.sv
module mcg_rand_state
   import mcg_rand_pkg::*;
#(
   parameter int unsigned          STATE_W     = 64,
   parameter logic [STATE_W-1:0]   MULT        = STATE_W'(MCG_MULT_64),
   parameter logic [STATE_W-1:0]   RESET_STATE = STATE_W'(MCG_RESET_64)
) (
   input  logic               clk,
   input  logic               rst,
   input  mcg_op_e            op,
   input  logic [STATE_W-1:0] seed,
   output logic [STATE_W-1:0] st_q
);

   logic [STATE_W-1:0] seed_odd;
   logic [STATE_W-1:0] mul_in;
   logic [STATE_W-1:0] mul_out;
   logic [STATE_W-1:0] st_d;

   // one shared multiplier: the seed path folds in the discarded first step
   always_comb begin
      seed_odd = (seed << 1) | STATE_W'(1);
      mul_in   = (op == OP_SEED) ? seed_odd : st_q;
      mul_out  = mul_in * MULT;
      st_d     = (op == OP_IDLE) ? st_q : mul_out;
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= RESET_STATE;
      else     st_q <= st_d;
   end

endmodule

// File: rtl/mcg_rand_perm.sv
module mcg_rand_perm #(
   parameter int unsigned STATE_W   = 64,
   parameter int unsigned OUT_W     = 32,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned XSHIFT    = 22,
   parameter bit          MUX_SHIFT = 1'b0
) (
   input  logic [STATE_W-1:0] st,
   output logic [OUT_W-1:0]   word
);

   localparam int unsigned NSEL   = 2 ** CNT_W;
   localparam int unsigned CNT_LO = STATE_W - CNT_W;

   logic [STATE_W-1:0] folded;
   logic [CNT_W-1:0]   cnt;

   assign cnt    = st[STATE_W-1:CNT_LO];
   assign folded = st ^ (st >> XSHIFT);

   generate
      if (MUX_SHIFT) begin : g_mux
         logic [OUT_W-1:0] cand [NSEL];
         for (genvar k = 0; k < NSEL; k++) begin : g_cand
            assign cand[k] = OUT_W'(folded >> (XSHIFT + k));
         end
         assign word = cand[cnt];
      end else begin : g_barrel
         assign word = OUT_W'(folded >> (XSHIFT + 32'(cnt)));
      end
   endgenerate

endmodule

// File: rtl/mcg_rand32.sv
module mcg_rand32
   import mcg_rand_pkg::*;
#(
   parameter int unsigned        STATE_W     = 64,
   parameter int unsigned        OUT_W       = 32,
   parameter int unsigned        CNT_W       = 3,
   parameter int unsigned        XSHIFT      = 22,
   parameter logic [STATE_W-1:0] MULT        = STATE_W'(MCG_MULT_64),
   parameter logic [STATE_W-1:0] RESET_STATE = STATE_W'(MCG_RESET_64),
   parameter bit                 MUX_SHIFT   = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               seed_load,
   input  logic [STATE_W-1:0] seed,
   input  logic               next,
   output logic [OUT_W-1:0]   rnd,
   output logic               rnd_valid
);

   localparam int unsigned MAX_SHIFT = XSHIFT + (2 ** CNT_W) - 1;

   generate
      if (CNT_W < 1 || CNT_W > 6) begin : g_bad_cnt
         $error("CNT_W must lie in 1..6");
      end
      if (MAX_SHIFT + OUT_W > STATE_W) begin : g_bad_width
         $error("largest output shift runs past the state width");
      end
      if (MULT[0] != 1'b1) begin : g_bad_mult
         $error("MULT must be odd to keep the state odd");
      end
      if (RESET_STATE[0] != 1'b1) begin : g_bad_reset
         $error("RESET_STATE must be odd");
      end
   endgenerate

   mcg_op_e            op;
   logic [STATE_W-1:0] st_q;
   logic [OUT_W-1:0]   perm_w;

   assign op = mcg_decode(seed_load, next);

   mcg_rand_state #(
      .STATE_W     (STATE_W),
      .MULT        (MULT),
      .RESET_STATE (RESET_STATE)
   ) u_state (
      .clk  (clk),
      .rst  (rst),
      .op   (op),
      .seed (seed),
      .st_q (st_q)
   );

   mcg_rand_perm #(
      .STATE_W   (STATE_W),
      .OUT_W     (OUT_W),
      .CNT_W     (CNT_W),
      .XSHIFT    (XSHIFT),
      .MUX_SHIFT (MUX_SHIFT)
   ) u_perm (
      .st   (st_q),
      .word (perm_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rnd       <= '0;
         rnd_valid <= 1'b0;
      end else begin
         rnd_valid <= (op == OP_STEP);
         if (op == OP_STEP) rnd <= perm_w;
      end
   end

endmodule

// File: rtl/mcg_rand32_chk.sv
module mcg_rand32_chk #(
   parameter int unsigned        STATE_W = 64,
   parameter int unsigned        OUT_W   = 32,
   parameter logic [STATE_W-1:0] MULT    = '1
) (
   input logic               clk,
   input logic               rst,
   input logic               seed_load,
   input logic [STATE_W-1:0] seed,
   input logic               next,
   input logic [OUT_W-1:0]   rnd,
   input logic               rnd_valid,
   input logic [STATE_W-1:0] st
);

   logic               step;
   logic [STATE_W-1:0] seed_exp;
   logic [STATE_W-1:0] adv_exp;

   always_comb begin
      step     = next && !seed_load;
      seed_exp = ((seed << 1) | STATE_W'(1)) * MULT;
      adv_exp  = st * MULT;
   end

   AST_STATE_ODD: assert property (@(posedge clk) disable iff (rst)
      st[0]);                                                   // R7
   AST_STATE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      step |=> (st == $past(adv_exp)));                         // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!next && !seed_load) |=> $stable(st));                   // R2
   AST_SEED_STEP: assert property (@(posedge clk) disable iff (rst)
      seed_load |=> (st == $past(seed_exp)));                   // R4
   AST_VALID_ON_STEP: assert property (@(posedge clk) disable iff (rst)
      step |=> rnd_valid);                                      // R5
   AST_NO_VALID_ELSE: assert property (@(posedge clk) disable iff (rst)
      !step |=> !rnd_valid);                                    // R6
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(rnd));                                  // R5

endmodule

bind mcg_rand32 mcg_rand32_chk #(
   .STATE_W (STATE_W),
   .OUT_W   (OUT_W),
   .MULT    (MULT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .seed_load (seed_load),
   .seed      (seed),
   .next      (next),
   .rnd       (rnd),
   .rnd_valid (rnd_valid),
   .st        (st_q)
);

// File: tb/mcg_rand32_test.sv
`timescale 1ns/1ps
module mcg_rand32_test;

   localparam longint unsigned K_MUL   = 64'd6364136223846793005;
   localparam longint unsigned K_RESET = 64'hcafef00dd15ea5e5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        seed_load = 1'b0;
   logic [63:0] seed = '0;
   logic        next = 1'b0;
   logic [31:0] rnd;
   logic        rnd_valid;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;

   // behavioural reference
   longint unsigned m_st;
   logic [31:0]     m_rnd;
   bit              m_valid;

   always #2 clk = ~clk;

   mcg_rand32 uut (
      .clk       (clk),
      .rst       (rst),
      .seed_load (seed_load),
      .seed      (seed),
      .next      (next),
      .rnd       (rnd),
      .rnd_valid (rnd_valid)
   );

   function automatic logic [31:0] ref_word(input longint unsigned s);
      int unsigned     c;
      longint unsigned x;
      c = int'(s >> 61);
      x = s ^ (s >> 22);
      return 32'(x >> (22 + c));
   endfunction

   task automatic compare(input string tag);
      n_tests++;
      if (rnd_valid !== m_valid || rnd !== m_rnd) begin
         n_fail++;
         $display("FAIL %s: rnd=%h valid=%b expected rnd=%h valid=%b",
                  tag, rnd, rnd_valid, m_rnd, m_valid);
      end
   endtask

   // check the previous cycle's result, then apply one cycle of stimulus
   task automatic cycle(input bit sl, input longint unsigned sd, input bit nx,
                        input string tag);
      @(negedge clk);
      compare(tag);
      seed_load = sl;
      seed      = sd;
      next      = nx;
      if (sl) begin
         m_st    = (sd * 2 + 1) * K_MUL;
         m_valid = 1'b0;
      end else if (nx) begin
         m_rnd   = ref_word(m_st);
         m_st    = m_st * K_MUL;
         m_valid = 1'b1;
      end else begin
         m_valid = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; seed_load = 1'b0; next = 1'b0; seed = '0;
      repeat (3) @(negedge clk);
      rst     = 1'b0;
      m_st    = K_RESET;
      m_rnd   = '0;
      m_valid = 1'b0;
   endtask

   initial begin
      #(4.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      cycle(0, 0, 0, "R1");                      // reset outputs
      cycle(0, 0, 1, "R1");                      // first word from reset state
      for (int i = 0; i < 8; i++) cycle(0, 0, 1, "R3");
      cycle(0, 0, 0, "R3");
      // gaps between requests
      cycle(0, 0, 1, "R5");
      cycle(0, 0, 0, "R5");
      cycle(0, 0, 0, "R5");
      cycle(0, 0, 1, "R5");
      cycle(0, 0, 0, "R5");
      // seeding
      cycle(1, 0, 0, "R4");
      for (int i = 0; i < 8; i++) cycle(0, 0, 1, "R4");
      cycle(1, 64'd42, 0, "R4");
      cycle(0, 0, 0, "R4");
      for (int i = 0; i < 10; i++) cycle(0, 0, 1, "R4");
      // seed load and request together
      cycle(1, 64'h0123_4567_89ab_cdef, 1, "R6");
      cycle(0, 0, 0, "R6");
      cycle(0, 0, 1, "R6");
      cycle(0, 0, 1, "R6");
      // doubling overflow seeds
      cycle(1, 64'hffff_ffff_ffff_ffff, 0, "R7");
      for (int i = 0; i < 4; i++) cycle(0, 0, 1, "R7");
      cycle(1, 64'h8000_0000_0000_0000, 0, "R7");
      for (int i = 0; i < 4; i++) cycle(0, 0, 1, "R7");
      // long irregular run
      for (int i = 0; i < 400; i++) begin
         cycle(($urandom % 50) == 0, {$urandom, $urandom}, ($urandom % 4) != 0, "R2");
      end
      cycle(0, 0, 0, "R2");
      // reset again in the middle of a run
      do_reset();
      cycle(0, 0, 1, "R1");
      cycle(0, 0, 1, "R1");
      cycle(0, 0, 0, "R1");
      cycle(0, 0, 0, "R1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule